// File: doc/BRIEF.md
# Serial-in parallel-out latched register

This block turns a serial bit stream into a parallel byte. It has two storage levels. A shift stage takes one serial bit on every rising edge of a shift clock. A storage latch copies the whole shift stage when its own storage clock rises, so the parallel outputs change only at that moment and never show a half-loaded word. An active-low clear empties the shift stage at once and does not touch the storage latch. An active-low output enable either presents the latched word on the parallel outputs or releases them. The released state is modelled as a per-bit drive-enable output, which stands in for high impedance. A cascade output carries the last shift stage bit, so several units can be chained into 16-bit or 24-bit words.

The shift clock, the storage clock and the serial input are treated as slow control signals. A fast system clock samples them through a short synchronizer. Rising edges are found by edge detection, so the whole block runs on a single clock.

Top module: `sipo_latch_reg`

## Requirements
- R1: While `rst_n` is low, the shift stage and the storage latch are cleared. After reset, `cascade_out` is 0, and `par_q` reads 0 whether or not the outputs are enabled.
- R2: Each rising edge of `shift_clk` moves every stage bit one place toward bit WIDTH-1 and loads `ser_in` into bit 0. Falling edges of `shift_clk`, and changes of `ser_in` while `shift_clk` stays high, do not change the stage.
- R3: After WIDTH shifts and a store, the first bit shifted in appears on `par_q[WIDTH-1]` and the last on `par_q[0]`.
- R4: A rising edge of `store_clk` copies all WIDTH stage bits into the latch together. Shifting alone never changes `par_q`.
- R5: When `clear_n` goes low, the shift stage is emptied right away, with no system clock edge needed, and `cascade_out` drops to 0.
- R6: `clear_n` has no effect on the storage latch. `par_q` keeps its value through a clear.
- R7: When `out_en_n` is 1, every bit of `par_drive` is 0 and every bit of `par_q` is 0. When `out_en_n` is 0, every bit of `par_drive` is 1 and `par_q` equals the latch. Both follow `out_en_n` without a clock.
- R8: `cascade_out` carries stage bit WIDTH-1. That is the bit shifted in WIDTH shift edges earlier, and each later shift edge brings out the next bit in order.
- R9: If a shift edge and a store edge are detected in the same cycle, the latch takes the stage contents from before that shift.
- R10: While `clear_n` is low, shift edges are ignored and the stage stays empty.
- R11: A change on `shift_clk` or `store_clk` takes effect at the (SYNC_DEPTH+1)-th rising edge of `clk` after it. With the default SYNC_DEPTH of 2, that is the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| ser_in | input | 1 | Serial data input |
| shift_clk | input | 1 | Shift clock; acts on its rising edge |
| store_clk | input | 1 | Storage clock; acts on its rising edge |
| clear_n | input | 1 | Active-low asynchronous clear of the shift stage |
| out_en_n | input | 1 | Active-low output enable |
| par_q | output | WIDTH | Parallel output (0 when released) |
| par_drive | output | WIDTH | Per-bit drive enable; 0 means high impedance |
| cascade_out | output | 1 | Last shift stage bit, for chaining |

## Verification
The bench loads the words A5, 3C, 80, 01, FF and C3. The asymmetric words show whether bit order is reversed. The single-bit words show whether one end of the register is lost or duplicated. All-ones after a clear shows whether the clear reaches every stage. Shifting zeros behind A5 checks the cascade sequence. Further tests toggle the serial input while the shift clock is held high, raise the shift and storage clocks together, and sample the output one cycle before and at the cycle it is due to change. These separate correct edge selection from level sensitivity, the pre-shift capture from the post-shift capture, and the right synchronizer latency from one cycle too short or too long.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

  // Default synchronizer depth for the slow control inputs.
  localparam int unsigned SIPO_SYNC_DEFAULT = 2;

  // Edge events found in one system clock cycle.
  typedef struct packed {
    logic store;
    logic shift;
  } sipo_evt_t;

endpackage

// File: rtl/sipo_edge_sampler.sv
// Samples slow edge inputs and data through a synchronizer chain of
// DEPTH stages. Reports one-cycle rising-edge pulses for the edge inputs
// and the delayed data aligned with those pulses.
module sipo_edge_sampler #(
  parameter int unsigned EW    = 2,
  parameter int unsigned DW    = 1,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] edge_raw,
  input  logic [DW-1:0] data_raw,
  output logic [EW-1:0] edge_rise,
  output logic [DW-1:0] data_lvl
);

  localparam int unsigned TW = EW + DW;

  logic [DEPTH-1:0][TW-1:0] pipe;
  logic [TW-1:0]            tail;
  logic [EW-1:0]            hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= {edge_raw, data_raw};
      for (int i = 1; i < DEPTH; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign tail = pipe[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= tail[TW-1:DW];
  end

  assign edge_rise = tail[TW-1:DW] & ~hist;
  assign data_lvl  = tail[DW-1:0];

endmodule

// File: rtl/sipo_shift_stage.sv
// Shift stage with an asynchronous clear. Bit 0 takes the serial input;
// the top bit is the cascade output.
module sipo_shift_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             adv,
  input  logic             ser,
  output logic [WIDTH-1:0] stage_q,
  output logic             tail_bit
);

  function automatic logic [WIDTH-1:0] step(input logic [WIDTH-1:0] cur,
                                            input logic b);
    return {cur[WIDTH-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)   stage_q <= '0;
    else if (adv) stage_q <= step(stage_q, ser);
  end

  assign tail_bit = stage_q[WIDTH-1];

endmodule

// File: rtl/sipo_store_latch.sv
// Output latch, loaded in parallel from the shift stage.
module sipo_store_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/sipo_out_drive.sv
// Per-bit output stage: a drive enable plus a value that reads 0 when
// the bit is released.
module sipo_out_drive #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] pin_val,
  output logic [WIDTH-1:0] pin_en
);

  for (genvar gb = 0; gb < WIDTH; gb++) begin : g_bit
    assign pin_en[gb]  = ~oe_n;
    assign pin_val[gb] = word[gb] & ~oe_n;
  end

endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg
  import sipo_pkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned SYNC_DEPTH = SIPO_SYNC_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             shift_clk,
  input  logic             store_clk,
  input  logic             clear_n,
  input  logic             out_en_n,
  output logic [WIDTH-1:0] par_q,
  output logic [WIDTH-1:0] par_drive,
  output logic             cascade_out
);

  localparam int unsigned EVW = $bits(sipo_evt_t);

  // Named internal events, brought out for the checker.
  sipo_evt_t        evt;
  logic [EVW-1:0]   evt_bits;
  logic             ser_s;
  logic             shift_rise;
  logic             store_rise;
  logic             stage_clr_n;
  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] latch_q;

  sipo_edge_sampler #(
    .EW    (EVW),
    .DW    (1),
    .DEPTH (SYNC_DEPTH)
  ) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_raw  ({store_clk, shift_clk}),
    .data_raw  (ser_in),
    .edge_rise (evt_bits),
    .data_lvl  (ser_s)
  );

  assign evt        = sipo_evt_t'(evt_bits);
  assign shift_rise = evt.shift;
  assign store_rise = evt.store;

  // The clear and the system reset both empty the shift stage asynchronously.
  assign stage_clr_n = rst_n & clear_n;

  sipo_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .clk      (clk),
    .clr_n    (stage_clr_n),
    .adv      (shift_rise),
    .ser      (ser_s),
    .stage_q  (shift_q),
    .tail_bit (cascade_out)
  );

  // The latch takes the shift stage as it was before any shift in the same cycle.
  sipo_store_latch #(.WIDTH(WIDTH)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (store_rise),
    .d     (shift_q),
    .q     (latch_q)
  );

  sipo_out_drive #(.WIDTH(WIDTH)) u_drive (
    .oe_n    (out_en_n),
    .word    (latch_q),
    .pin_val (par_q),
    .pin_en  (par_drive)
  );

endmodule

// File: rtl/sipo_latch_chk.sv
module sipo_latch_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_n,
  input logic             out_en_n,
  input logic             ser_s,
  input logic             shift_rise,
  input logic             store_rise,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] latch_q,
  input logic [WIDTH-1:0] par_q,
  input logic [WIDTH-1:0] par_drive,
  input logic             cascade_out
);

  // R2
  shift_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_rise && clear_n) |=>
      (!clear_n || shift_q == {$past(shift_q[WIDTH-2:0]), $past(ser_s)}));

  // R2
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_rise && clear_n) |=> (!clear_n || $stable(shift_q)));

  // R4, R9
  store_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_rise |=> latch_q == $past(shift_q));

  // R4, R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !store_rise |=> $stable(latch_q));

  // R5, R10
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |-> (shift_q == '0 && !cascade_out));

  // R7
  out_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (par_drive == '0 && par_q == '0));

  // R7
  out_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_n |-> (par_drive == '1 && par_q == latch_q));

  // R8
  cascade_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_rise && clear_n) |=> (!clear_n || cascade_out == $past(shift_q[WIDTH-2])));

endmodule

bind sipo_latch_reg sipo_latch_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clear_n     (clear_n),
  .out_en_n    (out_en_n),
  .ser_s       (ser_s),
  .shift_rise  (shift_rise),
  .store_rise  (store_rise),
  .shift_q     (shift_q),
  .latch_q     (latch_q),
  .par_q       (par_q),
  .par_drive   (par_drive),
  .cascade_out (cascade_out)
);

// File: tb/test_sipo_latch_reg.sv
module test_sipo_latch_reg;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_in = 1'b0;
  logic       shift_clk = 1'b0;
  logic       store_clk = 1'b0;
  logic       clear_n = 1'b1;
  logic       out_en_n = 1'b1;
  logic [7:0] par_q;
  logic [7:0] par_drive;
  logic       cascade_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sipo_latch_reg i_sipo_latch_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_in      (ser_in),
    .shift_clk   (shift_clk),
    .store_clk   (store_clk),
    .clear_n     (clear_n),
    .out_en_n    (out_en_n),
    .par_q       (par_q),
    .par_drive   (par_drive),
    .cascade_out (cascade_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_shift(input logic b);
    @(negedge clk);
    ser_in = b;
    repeat (4) @(negedge clk);
    shift_clk = 1'b1;
    repeat (4) @(negedge clk);
    shift_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic shift_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) pulse_shift(b[i]);
  endtask

  task automatic pulse_store();
    @(negedge clk);
    store_clk = 1'b1;
    repeat (4) @(negedge clk);
    store_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic quick_clear();
    @(negedge clk);
    clear_n = 1'b0;
    @(negedge clk);
    clear_n = 1'b1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 drive released", {24'd0, par_drive}, 32'h00);
    out_en_n = 1'b0;
    #1;
    chk("R1 par_q after reset", {24'd0, par_q}, 32'h00);
    chk("R1 cascade after reset", {31'd0, cascade_out}, 32'd0);
  endtask

  task automatic t_order();
    shift_byte(8'hA5);
    chk("R4 shift alone keeps par_q", {24'd0, par_q}, 32'h00);
    chk("R8 cascade holds first bit", {31'd0, cascade_out}, 32'd1);
    pulse_store();
    chk("R3 order A5", {24'd0, par_q}, 32'hA5);
    for (int k = 6; k >= 0; k--) begin
      pulse_shift(1'b0);
      chk("R8 cascade sequence", {31'd0, cascade_out}, {31'd0, 1'b1 & (8'hA5 >> k)});
    end
    chk("R4 latch unchanged by shifts", {24'd0, par_q}, 32'hA5);
  endtask

  task automatic t_patterns();
    shift_byte(8'h3C); pulse_store();
    chk("R3 order 3C", {24'd0, par_q}, 32'h3C);
    shift_byte(8'h80); pulse_store();
    chk("R3 order 80", {24'd0, par_q}, 32'h80);
    shift_byte(8'h01); pulse_store();
    chk("R3 order 01", {24'd0, par_q}, 32'h01);
  endtask

  task automatic t_edges();
    quick_clear();
    @(negedge clk);
    ser_in = 1'b1;
    repeat (4) @(negedge clk);
    shift_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_in = 1'b0;
    repeat (4) @(negedge clk);
    ser_in = 1'b1;
    repeat (4) @(negedge clk);
    ser_in = 1'b0;
    shift_clk = 1'b0;
    repeat (6) @(negedge clk);
    pulse_store();
    chk("R2 only rising edge shifts", {24'd0, par_q}, 32'h01);
    pulse_shift(1'b0);
    pulse_store();
    chk("R2 next shift", {24'd0, par_q}, 32'h02);
  endtask

  task automatic t_clear();
    shift_byte(8'hFF); pulse_store();
    chk("R3 order FF", {24'd0, par_q}, 32'hFF);
    pulse_shift(1'b0);
    @(negedge clk);
    clear_n = 1'b0;
    #1;
    chk("R5 cascade cleared without clock", {31'd0, cascade_out}, 32'd0);
    chk("R6 latch kept at clear", {24'd0, par_q}, 32'hFF);
    pulse_shift(1'b1);
    chk("R6 latch kept during clear", {24'd0, par_q}, 32'hFF);
    pulse_store();
    chk("R10 shift ignored in clear", {24'd0, par_q}, 32'h00);
    @(negedge clk);
    clear_n = 1'b1;
    pulse_shift(1'b1);
    pulse_store();
    chk("R5 stage emptied", {24'd0, par_q}, 32'h01);
  endtask

  task automatic t_enable();
    @(negedge clk);
    out_en_n = 1'b1;
    #1;
    chk("R7 released drive", {24'd0, par_drive}, 32'h00);
    chk("R7 released value", {24'd0, par_q}, 32'h00);
    out_en_n = 1'b0;
    #1;
    chk("R7 enabled drive", {24'd0, par_drive}, 32'hFF);
    chk("R7 enabled value", {24'd0, par_q}, 32'h01);
  endtask

  task automatic t_same_cycle();
    quick_clear();
    shift_byte(8'hC3);
    @(negedge clk);
    ser_in = 1'b1;
    repeat (4) @(negedge clk);
    shift_clk = 1'b1;
    store_clk = 1'b1;
    repeat (4) @(negedge clk);
    shift_clk = 1'b0;
    store_clk = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 latch takes pre-shift stage", {24'd0, par_q}, 32'hC3);
    pulse_store();
    chk("R9 stage shifted", {24'd0, par_q}, 32'h87);
  endtask

  task automatic t_latency();
    pulse_shift(1'b0);
    @(negedge clk);
    store_clk = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R11 not yet after two edges", {24'd0, par_q}, 32'h87);
    @(negedge clk);
    chk("R11 updated at third edge", {24'd0, par_q}, 32'h0E);
    store_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_order();
    t_patterns();
    t_edges();
    t_clear();
    t_enable();
    t_same_cycle();
    t_latency();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule